// File: doc/BRIEF.md
# Dual-Clock FIFO with Byte-Loaded Threshold Offsets

This block is a first-in first-out buffer of 9-bit words. The write port and the read port each have their own clock. Its depth is a power-of-two parameter from 256 to 8192 words. It drives four active-low status outputs. The full and almost-full flags belong to the write clock, and the empty and almost-empty flags belong to the read clock. The write and read pointers cross between the two clocks as Gray code through two-stage synchronizers. Each pointer carries one extra wrap bit, so that a full buffer and an empty buffer can be told apart.

A mode input, `arr_mode`, selects what the two strobes act on. When `arr_mode` is high, the strobes move words into and out of the array. When `arr_mode` is low, the same strobes act on a bank of four threshold bytes that set the almost-empty and almost-full levels. Each access reaches the next byte in a fixed rotation, writes through `din` and reads out on `dout`. The offset bank is meant to be loaded while the array is idle. Accessing the bank from both sides in the same cycle is not supported. A chip that needs two independent buffers places two instances of this block.

Top module: `ofsfifo_top`

## Requirements
- R1: After reset the block is in its idle state. `empty_n`=0, `full_n`=1, `aempty_n`=0, `afull_n`=1 and `dout`=0. Both threshold offsets read back as 0x007: the low byte holds 0x07 and the high part holds 0.
- R2: When `arr_mode`=1, `wr_en`=1 and the buffer is not full, the word on `din` is stored on the rising edge of `wr_clk`. When `arr_mode`=1, `rd_en`=1 and the buffer is not empty, `dout` takes the oldest stored word on the rising edge of `rd_clk`. Words leave in the order they were written, including after the pointers wrap.
- R3: When `arr_mode`=0 and `wr_en`=1, `din` is written into the offset byte that the write selector points at, and nothing enters the array. The selector steps through 0 (empty offset low byte), 1 (empty offset high part), 2 (full offset low byte) and 3 (full offset high part), then wraps back to 0. Reset sets it to 0.
- R4: When `arr_mode`=0 and `rd_en`=1, `dout` takes the selected offset byte, zero-extended to 9 bits, on the rising edge of `rd_clk`. A separate read selector follows the same 0-1-2-3 rotation. A low byte keeps `din[7:0]`. A high part keeps `din[H-1:0]`, where H = max(log2(DEPTH)-8, 1). An offset read does not change the array contents.
- R5: While `wr_en`=0, no write of any kind takes place. While `rd_en`=0, no read of any kind takes place and `dout` holds its value.
- R6: `full_n` goes low once DEPTH words are held. With no reads, this happens right after the DEPTH-th write edge. A write attempted while full is dropped.
- R7: `empty_n` is low whenever the read pointer equals the synchronized write pointer. A read attempted while empty is dropped, and `dout` keeps its last value.
- R8: `aempty_n` is low while the occupancy seen by the read side is at or below the empty offset.
- R9: `afull_n` is low while the free space seen by the write side is at or below the full offset.
- R10: After the other side moves a pointer, a flag recovers within a few cycles of its own clock. `full_n` returns high after a read, and `empty_n` returns high after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| arr_mode | input | 1 | 1: strobes act on the array; 0: strobes act on the offset bank |
| wr_en | input | 1 | Write strobe, sampled on `wr_clk` |
| rd_en | input | 1 | Read strobe, sampled on `rd_clk` |
| din | input | 9 | Write data or offset byte |
| dout | output | 9 | Read data or offset readback |
| full_n | output | 1 | Low when full (write clock) |
| afull_n | output | 1 | Low when free space is at or below the full offset (write clock) |
| empty_n | output | 1 | Low when empty (read clock) |
| aempty_n | output | 1 | Low when occupancy is at or below the empty offset (read clock) |

## Verification
The hardest state to reach from the ports is the full boundary. The stimulus must hold the buffer at exactly DEPTH words, try an extra write there, and then read an offset while full, so that the rotation and the array are both seen to be untouched. The bench first loads small offsets through the rotating selector, including a wrap of the selector and an oversized high byte. It then writes word by word up to the almost-full and full edges, waiting for the pointers to synchronize before each flag check. Draining the buffer afterwards confirms that the dropped word never appears. A further short burst confirms the ordering once the pointers have wrapped.

// File: rtl/ofsfifo_pkg.sv
package ofsfifo_pkg;
  localparam int DATA_W = 9;
  localparam int LO_W   = 8;
  localparam int FN_W   = 16;

  typedef enum logic [1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } ofs_sel_e;

  function automatic logic [FN_W-1:0] bin2gray(input logic [FN_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [FN_W-1:0] gray2bin(input logic [FN_W-1:0] g);
    logic [FN_W-1:0] b;
    b[FN_W-1] = g[FN_W-1];
    for (int i = FN_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic at_or_below(input logic [FN_W-1:0] level,
                                       input logic [FN_W-1:0] limit);
    return level <= limit;
  endfunction
endpackage

// File: rtl/ofsfifo_sync.sv
module ofsfifo_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ofsfifo_mem.sv
module ofsfifo_mem #(
  parameter int DEPTH = 256,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/ofsfifo_ofs.sv
module ofsfifo_ofs
  import ofsfifo_pkg::*;
#(
  parameter int HI_W = 1,
  localparam int OW  = LO_W + HI_W
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ld_re,
  output logic [OW-1:0]     empty_ofs,
  output logic [OW-1:0]     full_ofs,
  output logic [DATA_W-1:0] rd_byte,
  output logic [1:0]        wsel
);
  logic [LO_W-1:0] e_lo, f_lo;
  logic [HI_W-1:0] e_hi, f_hi;
  ofs_sel_e        wsel_q, rsel_q;

  // Load side: one byte per write strobe, rotating selector.
  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      e_lo   <= LO_W'(7);
      e_hi   <= '0;
      f_lo   <= LO_W'(7);
      f_hi   <= '0;
      wsel_q <= SEL_EMPTY_LO;
    end else if (ld_we) begin
      unique case (wsel_q)
        SEL_EMPTY_LO: e_lo <= wdata[LO_W-1:0];
        SEL_EMPTY_HI: e_hi <= wdata[HI_W-1:0];
        SEL_FULL_LO:  f_lo <= wdata[LO_W-1:0];
        SEL_FULL_HI:  f_hi <= wdata[HI_W-1:0];
      endcase
      wsel_q <= ofs_sel_e'(wsel_q + 2'd1);
    end
  end

  // Readback side: its own selector stepping on the read clock.
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) rsel_q <= SEL_EMPTY_LO;
    else if (ld_re) rsel_q <= ofs_sel_e'(rsel_q + 2'd1);
  end

  always_comb begin
    unique case (rsel_q)
      SEL_EMPTY_LO: rd_byte = DATA_W'(e_lo);
      SEL_EMPTY_HI: rd_byte = DATA_W'(e_hi);
      SEL_FULL_LO:  rd_byte = DATA_W'(f_lo);
      SEL_FULL_HI:  rd_byte = DATA_W'(f_hi);
    endcase
  end

  assign empty_ofs = {e_hi, e_lo};
  assign full_ofs  = {f_hi, f_lo};
  assign wsel      = wsel_q;
endmodule

// File: rtl/ofsfifo_top.sv
module ofsfifo_top
  import ofsfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int HI_W = (AW > LO_W) ? AW - LO_W : 1,
  localparam int OW   = LO_W + HI_W
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              arr_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              full_n,
  output logic              afull_n,
  output logic              empty_n,
  output logic              aempty_n
);
  // Write-side state and named events
  logic [PW-1:0] wptr_bin, wptr_gray, rgray_wr, rptr_wr, wr_fill, wr_free;
  logic          wr_full, wr_push, ld_we;
  // Read-side state and named events
  logic [PW-1:0] rptr_bin, rptr_gray, wgray_rd, wptr_rd, rd_fill;
  logic          rd_empty, rd_pop, ld_re;
  // Offset bank
  logic [OW-1:0]     empty_ofs, full_ofs;
  logic [DATA_W-1:0] ofs_byte, mem_rdata;
  logic [1:0]        ofs_wsel;

  // ---------------- write side ----------------
  assign rptr_wr = PW'(gray2bin(FN_W'(rgray_wr)));
  assign wr_fill = wptr_bin - rptr_wr;
  assign wr_free = PW'(DEPTH) - wr_fill;
  assign wr_full = (wr_fill == PW'(DEPTH));
  assign wr_push = wr_en && arr_mode && !wr_full;
  assign ld_we   = wr_en && !arr_mode;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (wr_push) begin
      wptr_bin  <= wptr_bin + 1'b1;
      wptr_gray <= PW'(bin2gray(FN_W'(wptr_bin + 1'b1)));
    end
  end

  assign full_n  = !wr_full;
  assign afull_n = !at_or_below(FN_W'(wr_free), FN_W'(full_ofs));

  // ---------------- read side ----------------
  assign wptr_rd  = PW'(gray2bin(FN_W'(wgray_rd)));
  assign rd_fill  = wptr_rd - rptr_bin;
  assign rd_empty = (rd_fill == '0);
  assign rd_pop   = rd_en && arr_mode && !rd_empty;
  assign ld_re    = rd_en && !arr_mode;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      dout      <= '0;
    end else if (rd_pop) begin
      rptr_bin  <= rptr_bin + 1'b1;
      rptr_gray <= PW'(bin2gray(FN_W'(rptr_bin + 1'b1)));
      dout      <= mem_rdata;
    end else if (ld_re) begin
      dout      <= ofs_byte;
    end
  end

  assign empty_n  = !rd_empty;
  assign aempty_n = !at_or_below(FN_W'(rd_fill), FN_W'(empty_ofs));

  // ---------------- submodules ----------------
  ofsfifo_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rptr_gray), .q(rgray_wr)
  );

  ofsfifo_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wptr_gray), .q(wgray_rd)
  );

  ofsfifo_mem #(.DEPTH(DEPTH), .W(DATA_W)) u_mem (
    .wr_clk(wr_clk),
    .we    (wr_push),
    .waddr (wptr_bin[AW-1:0]),
    .wdata (din),
    .raddr (rptr_bin[AW-1:0]),
    .rdata (mem_rdata)
  );

  ofsfifo_ofs #(.HI_W(HI_W)) u_ofs (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .rst_n    (rst_n),
    .ld_we    (ld_we),
    .wdata    (din),
    .ld_re    (ld_re),
    .empty_ofs(empty_ofs),
    .full_ofs (full_ofs),
    .rd_byte  (ofs_byte),
    .wsel     (ofs_wsel)
  );
endmodule

// File: rtl/ofsfifo_chk.sv
module ofsfifo_chk #(
  parameter int DEPTH = 256,
  parameter int PW    = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          arr_mode,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] rptr_bin,
  input logic [PW-1:0] wr_fill,
  input logic [1:0]    wsel
);
  // R2
  push_adv_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && arr_mode && full_n) |=> (wptr_bin == PW'($past(wptr_bin) + 1'b1)));

  // R6
  full_block_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && arr_mode && !full_n) |=> $stable(wptr_bin));

  // R6
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_fill <= PW'(DEPTH)));

  // R3
  ofs_wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && !arr_mode) |=> $stable(wptr_bin));

  // R3
  sel_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && !arr_mode) |=> (wsel == 2'($past(wsel) + 2'd1)));

  // R7
  empty_block_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && arr_mode && !empty_n) |=> $stable(rptr_bin));

  // R4
  ofs_rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && !arr_mode) |=> $stable(rptr_bin));

  // R8
  empty_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n) |-> (!aempty_n));
endmodule

bind ofsfifo_top ofsfifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk  (wr_clk),
  .rd_clk  (rd_clk),
  .rst_n   (rst_n),
  .arr_mode(arr_mode),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .full_n  (full_n),
  .empty_n (empty_n),
  .aempty_n(aempty_n),
  .wptr_bin(wptr_bin),
  .rptr_bin(rptr_bin),
  .wr_fill (wr_fill),
  .wsel    (ofs_wsel)
);

// File: tb/ofsfifo_top_tb_top.sv
module ofsfifo_top_tb_top;
  localparam int DEPTH = 256;

  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic       arr_mode = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       full_n, afull_n, empty_n, aempty_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 wr_clk = ~wr_clk;
  always #3 rd_clk = ~rd_clk;

  ofsfifo_top #(.DEPTH(DEPTH)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .arr_mode(arr_mode), .wr_en(wr_en), .rd_en(rd_en),
    .din(din), .dout(dout),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 11) & 'h1FF);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [8:0] v);
    @(negedge wr_clk); arr_mode = 1'b1; wr_en = 1'b1; din = v;
    @(negedge wr_clk); wr_en = 1'b0;
  endtask

  task automatic ofs_write(input logic [8:0] v);
    @(negedge wr_clk); arr_mode = 1'b0; wr_en = 1'b1; din = v;
    @(negedge wr_clk); wr_en = 1'b0; arr_mode = 1'b1;
  endtask

  task automatic pop(output logic [8:0] v);
    @(negedge rd_clk); arr_mode = 1'b1; rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0; v = dout;
  endtask

  task automatic ofs_read(output logic [8:0] v);
    @(negedge rd_clk); arr_mode = 1'b0; rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0; arr_mode = 1'b1; v = dout;
  endtask

  task automatic settle;
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic t_reset;
    logic [8:0] v;
    check("R1", "empty_n", empty_n, 0);
    check("R1", "full_n", full_n, 1);
    check("R1", "aempty_n", aempty_n, 0);
    check("R1", "afull_n", afull_n, 1);
    check("R1", "dout", dout, 0);
    ofs_read(v); check("R1", "empty_lo default", v, 'h07);
    ofs_read(v); check("R1", "empty_hi default", v, 'h00);
    ofs_read(v); check("R1", "full_lo default", v, 'h07);
    ofs_read(v); check("R1", "full_hi default", v, 'h00);
    check("R4", "offset read leaves array empty", empty_n, 0);
  endtask

  task automatic t_offsets;
    logic [8:0] v;
    ofs_write(9'h1AB); ofs_write(9'h1FF); ofs_write(9'h0C3); ofs_write(9'h0FE);
    ofs_write(9'h105);
    settle;
    check("R3", "offset writes store nothing in array", empty_n, 0);
    ofs_read(v); check("R3", "sel0 after wrap", v, 'h05);
    ofs_read(v); check("R4", "high part masked", v, 'h001);
    ofs_read(v); check("R3", "sel2", v, 'h0C3);
    ofs_read(v); check("R4", "sel3 masked", v, 'h000);
    ofs_read(v); check("R4", "read selector wraps", v, 'h05);
    ofs_write(9'h000); ofs_write(9'h003); ofs_write(9'h000);
    ofs_read(v); check("R3", "empty_hi rewritten", v, 'h000);
    ofs_read(v); check("R3", "full_lo rewritten", v, 'h003);
    ofs_read(v); check("R3", "full_hi rewritten", v, 'h000);
  endtask

  task automatic t_noop;
    logic [8:0] v;
    for (int i = 0; i < 6; i++) begin
      @(negedge wr_clk); arr_mode = i[0]; wr_en = 1'b0; din = 9'(i * 51);
    end
    arr_mode = 1'b1;
    settle;
    check("R5", "idle strobes leave array empty", empty_n, 0);
    ofs_read(v); check("R5", "empty_lo unchanged", v, 'h05);
    ofs_read(v); check("R5", "empty_hi unchanged", v, 'h00);
    ofs_read(v); check("R5", "full_lo unchanged", v, 'h03);
    ofs_read(v); check("R5", "full_hi unchanged", v, 'h00);
    check("R5", "dout held while rd_en low", dout, 'h00);
  endtask

  task automatic t_fill_drain;
    logic [8:0] v;
    int bad;
    for (int i = 0; i < 5; i++) push(pat(i));
    settle;
    check("R10", "empty_n after writes", empty_n, 1);
    check("R8", "aempty at occupancy 5", aempty_n, 0);
    push(pat(5));
    settle;
    check("R8", "aempty clear at occupancy 6", aempty_n, 1);
    for (int i = 6; i < DEPTH - 4; i++) push(pat(i));
    settle;
    check("R9", "afull clear with free 4", afull_n, 1);
    check("R6", "not full with free 4", full_n, 1);
    push(pat(DEPTH - 4));
    check("R9", "afull with free 3", afull_n, 0);
    for (int i = DEPTH - 3; i < DEPTH; i++) push(pat(i));
    check("R6", "full after DEPTH writes", full_n, 0);
    push(9'h1EE);
    ofs_read(v); check("R4", "offset read while full", v, 'h05);
    ofs_read(v); ofs_read(v); ofs_read(v);
    check("R6", "still full after offset reads", full_n, 0);
    pop(v); check("R2", "first word out", v, pat(0));
    settle;
    check("R10", "full_n recovers after read", full_n, 1);
    check("R9", "afull with free 1", afull_n, 0);
    bad = 0;
    for (int i = 1; i < DEPTH; i++) begin
      pop(v);
      if (v != pat(i)) bad++;
    end
    check("R2", "drain order mismatches", bad, 0);
    check("R7", "empty after last word", empty_n, 0);
    pop(v); check("R7", "read while empty keeps dout", v, pat(DEPTH - 1));
    settle;
    check("R6", "dropped word never stored", empty_n, 0);
    check("R9", "afull clear when empty", afull_n, 1);
  endtask

  task automatic t_wrap;
    logic [8:0] v;
    push(9'h101); push(9'h0AA); push(9'h155);
    settle;
    pop(v); check("R2", "wrapped word 0", v, 'h101);
    pop(v); check("R2", "wrapped word 1", v, 'h0AA);
    pop(v); check("R2", "wrapped word 2", v, 'h155);
    check("R7", "empty after wrapped burst", empty_n, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wr_clk);
    #1;
    t_reset_pre_release();
    rst_n = 1'b1;
    repeat (2) @(negedge rd_clk);
    t_reset;
    t_offsets;
    t_noop;
    t_fill_drain;
    t_wrap;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  task automatic t_reset_pre_release;
    check("R1", "empty_n during reset", empty_n, 0);
    check("R1", "full_n during reset", full_n, 1);
  endtask
endmodule